// File: doc/BRIEF.md
# Byte-to-Word Data FIFO Engine

This block sits between a host that moves 32-bit words and a card data port that moves one byte at a time. It holds a small circular FIFO of words. In the card-to-host direction it gathers incoming bytes into words and queues them for the host to pop. In the host-to-card direction it takes words the host has pushed and hands them to the card one byte at a time. Bytes map onto words little-endian in both directions.

A transfer begins with a one-cycle start pulse. The pulse loads a 16-bit byte count and latches the direction. A remaining-byte counter then falls by one for each byte that crosses the card port. The block raises the end-of-data and end-of-block indications once the counter reaches zero. The transfer stays enabled until the FIFO has also drained. While the transfer is live, a five-bit level-flag vector is reported for the active direction only. The flag vector for the other direction stays at zero.

Top module: `byte_word_fifo_engine`

## Requirements
- R1: While reset is asserted and just after it, `xfer_en_o`, `remaining_o`, both flag vectors, both end flags, `card_rx_ready_o`, `card_tx_valid_o` and `host_rdata_o` are all zero, and the latched direction is host-to-card.
- R2: A cycle with `start_i` high loads `remaining_o` with `len_i` and sets `xfer_en_o` from the next cycle on. It latches `dir_rd_i` (1 = card-to-host, 0 = host-to-card) and resets the byte lane of the packer and the unpacker to zero. No card byte moves in the start cycle.
- R3: `card_rx_ready_o` is high exactly when the transfer is enabled, the direction is card-to-host, `remaining_o` is nonzero, the FIFO holds fewer than 16 words and `start_i` is low. The first accepted byte lands in bits 7:0, the next in 15:8, and so on. A word is queued after every fourth byte.
- R4: When the count reaches zero partway through a word, that word is still queued, and its unfilled upper bytes are zero.
- R5: `card_tx_valid_o` is high exactly when the transfer is enabled, the direction is host-to-card, `remaining_o` is nonzero, `start_i` is low, and either unsent bytes remain from the current word or the FIFO is non-empty. Each word leaves least significant byte first on `card_tx_data_o`, and a byte moves on a cycle with valid and `card_tx_ready_i` both high.
- R6: `remaining_o` decreases by exactly one for every byte accepted from or sent to the card.
- R7: From the first start pulse on, `data_end_o` and `blk_end_o` are both high whenever `remaining_o` is zero.
- R8: When the transfer is enabled, `remaining_o` is zero, the FIFO is empty and no start is given, `xfer_en_o` is low from the next cycle on. While that condition holds or the transfer is off, both flag vectors are zero.
- R9: During a live transfer, the active flag vector reads as follows. Bit 0 is the active bit. Bit 1 means the FIFO holds 0 words and bit 2 means it holds more than 0. Bit 3 means it holds 16 words. Bit 4 means it holds 8 or fewer in the host-to-card direction, or 8 or more in the card-to-host direction.
- R10: Only `tx_flags_o` is nonzero when the direction is host-to-card, and only `rx_flags_o` when the direction is card-to-host.
- R11: A host push is ignored when the FIFO is full or the direction is card-to-host. A host pop is ignored when the FIFO is empty or the direction is host-to-card. `host_rdata_o` shows the oldest word, or zero when the FIFO is empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle pulse that begins a transfer |
| dir_rd_i | input | 1 | Direction sampled on start: 1 card-to-host, 0 host-to-card |
| len_i | input | 16 | Byte count sampled on start |
| host_push_i | input | 1 | Host pushes `host_wdata_i` into the FIFO |
| host_wdata_i | input | 32 | Word pushed by the host |
| host_pop_i | input | 1 | Host removes the oldest word |
| host_rdata_o | output | 32 | Oldest word in the FIFO, zero when empty |
| card_rx_ready_o | output | 1 | Engine can take a byte from the card |
| card_rx_valid_i | input | 1 | Card offers a byte |
| card_rx_data_i | input | 8 | Byte from the card |
| card_tx_valid_o | output | 1 | Engine offers a byte to the card |
| card_tx_data_o | output | 8 | Byte to the card |
| card_tx_ready_i | input | 1 | Card takes the offered byte |
| xfer_en_o | output | 1 | Transfer enabled |
| remaining_o | output | 16 | Bytes still to move across the card port |
| tx_flags_o | output | 5 | Level flags for the host-to-card direction |
| rx_flags_o | output | 5 | Level flags for the card-to-host direction |
| data_end_o | output | 1 | Byte count exhausted |
| blk_end_o | output | 1 | Block finished, same as data end |

## Verification
A wrong fill count shows up at once in the level-flag vectors and in `card_rx_ready_o`. A wrong read position shows in `host_rdata_o` in the same cycle. A slip in the pack or unpack lane only shows when the affected word reaches the other side: a shuffled word at the next host pop, or a misordered byte on the next card-side byte. A counter that skips or repeats a decrement first shows in `remaining_o`. If it goes uncaught there, the end flags rise early or late, and the enable drops one cycle after the counter and the FIFO are both at zero.

// File: rtl/bwf_pkg.sv
package bwf_pkg;
  localparam int FLAG_W    = 5;
  localparam int FL_ACTIVE = 0;
  localparam int FL_EMPTY  = 1;
  localparam int FL_AVAIL  = 2;
  localparam int FL_FULL   = 3;
  localparam int FL_HALF   = 4;

  // Level flags for a live transfer; the half bit flips sense by side.
  function automatic logic [FLAG_W-1:0] level_flags(int unsigned fill,
                                                    int unsigned depth,
                                                    logic rx_side);
    logic [FLAG_W-1:0] f;
    f            = '0;
    f[FL_ACTIVE] = 1'b1;
    f[FL_EMPTY]  = (fill == 0);
    f[FL_AVAIL]  = (fill != 0);
    f[FL_FULL]   = (fill == depth);
    f[FL_HALF]   = rx_side ? (fill >= depth / 2) : (fill <= depth / 2);
    return f;
  endfunction
endpackage

// File: rtl/bwf_word_ring.sv
module bwf_word_ring #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 32,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_req,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_req,
  output logic [WIDTH-1:0] head,
  output logic [CW-1:0]    fill
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    rptr;
  logic [AW-1:0]    wptr;
  logic             do_wr;
  logic             do_rd;

  // DEPTH is a power of two, so the write slot wraps by truncation.
  assign wptr  = rptr + fill[AW-1:0];
  assign do_wr = wr_req && (fill < CW'(DEPTH));
  assign do_rd = rd_req && (fill != '0);
  assign head  = mem[rptr];

  always_ff @(posedge clk) begin
    if (do_wr) mem[wptr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rptr <= '0;
      fill <= '0;
    end else begin
      if (do_rd) rptr <= rptr + AW'(1);
      case ({do_wr, do_rd})
        2'b10:   fill <= fill + CW'(1);
        2'b01:   fill <= fill - CW'(1);
        default: fill <= fill;
      endcase
    end
  end
endmodule

// File: rtl/bwf_packer.sv
module bwf_packer #(
  parameter int WIDTH = 32,
  localparam int WORD_BYTES = WIDTH / 8,
  localparam int LANE_W = $clog2(WORD_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             take,
  input  logic             last,
  input  logic [7:0]       byte_in,
  output logic             push,
  output logic [WIDTH-1:0] push_word
);
  logic [WIDTH-1:0]  acc;
  logic [LANE_W-1:0] lane;

  function automatic logic [WIDTH-1:0] place_byte(logic [WIDTH-1:0] base,
                                                  logic [7:0] b,
                                                  logic [LANE_W-1:0] ln);
    logic [WIDTH-1:0] ext;
    ext = WIDTH'(b);
    return base | (ext << (32'(ln) * 8));
  endfunction

  assign push_word = place_byte(acc, byte_in, lane);
  assign push      = take && (last || (lane == LANE_W'(WORD_BYTES - 1)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc  <= '0;
      lane <= '0;
    end else if (restart) begin
      acc  <= '0;
      lane <= '0;
    end else if (take) begin
      if (push) begin
        acc  <= '0;
        lane <= '0;
      end else begin
        acc  <= push_word;
        lane <= lane + LANE_W'(1);
      end
    end
  end
endmodule

// File: rtl/bwf_unpacker.sv
module bwf_unpacker #(
  parameter int WIDTH = 32,
  localparam int WORD_BYTES = WIDTH / 8,
  localparam int LANE_W = $clog2(WORD_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             give,
  input  logic [WIDTH-1:0] head,
  output logic             have_bytes,
  output logic             need_pop,
  output logic [7:0]       byte_out
);
  logic [WIDTH-1:0]  hold;
  logic [LANE_W-1:0] left;

  assign have_bytes = (left != '0);
  assign need_pop   = give && !have_bytes;
  assign byte_out   = have_bytes ? hold[7:0] : head[7:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold <= '0;
      left <= '0;
    end else if (restart) begin
      left <= '0;
    end else if (give) begin
      if (!have_bytes) begin
        hold <= head >> 8;
        left <= LANE_W'(WORD_BYTES - 1);
      end else begin
        hold <= hold >> 8;
        left <= left - LANE_W'(1);
      end
    end
  end
endmodule

// File: rtl/bwf_status.sv
module bwf_status
  import bwf_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              live,
  input  logic              rd_dir,
  input  logic [CW-1:0]     fill,
  output logic [FLAG_W-1:0] tx_flags,
  output logic [FLAG_W-1:0] rx_flags
);
  logic [FLAG_W-1:0] lvl_tx;
  logic [FLAG_W-1:0] lvl_rx;

  assign lvl_tx   = level_flags(32'(fill), DEPTH, 1'b0);
  assign lvl_rx   = level_flags(32'(fill), DEPTH, 1'b1);
  assign tx_flags = (live && !rd_dir) ? lvl_tx : '0;
  assign rx_flags = (live &&  rd_dir) ? lvl_rx : '0;
endmodule

// File: rtl/byte_word_fifo_engine.sv
module byte_word_fifo_engine
  import bwf_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int WIDTH = 32,
  parameter int LEN_W = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              dir_rd_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              host_push_i,
  input  logic [WIDTH-1:0]  host_wdata_i,
  input  logic              host_pop_i,
  output logic [WIDTH-1:0]  host_rdata_o,
  output logic              card_rx_ready_o,
  input  logic              card_rx_valid_i,
  input  logic [7:0]        card_rx_data_i,
  output logic              card_tx_valid_o,
  output logic [7:0]        card_tx_data_o,
  input  logic              card_tx_ready_i,
  output logic              xfer_en_o,
  output logic [LEN_W-1:0]  remaining_o,
  output logic [FLAG_W-1:0] tx_flags_o,
  output logic [FLAG_W-1:0] rx_flags_o,
  output logic              data_end_o,
  output logic              blk_end_o
);
  logic             en;
  logic             rd_dir;
  logic             armed;
  logic [LEN_W-1:0] cnt;
  logic [CW-1:0]    fill;
  logic [WIDTH-1:0] head;
  logic             cnt_zero;
  logic             fifo_empty;
  logic             drained;
  logic             rx_take;
  logic             tx_give;
  logic             byte_mv;
  logic             pk_push;
  logic [WIDTH-1:0] pk_word;
  logic             up_have;
  logic             up_pop;
  logic             ring_wr;
  logic             ring_rd;
  logic [WIDTH-1:0] ring_wdata;

  assign cnt_zero   = (cnt == '0);
  assign fifo_empty = (fill == '0);
  assign drained    = cnt_zero && fifo_empty;

  assign card_rx_ready_o = en && rd_dir && !cnt_zero && (fill < CW'(DEPTH)) && !start_i;
  assign card_tx_valid_o = en && !rd_dir && !cnt_zero && (up_have || !fifo_empty) && !start_i;
  assign rx_take = card_rx_ready_o && card_rx_valid_i;
  assign tx_give = card_tx_valid_o && card_tx_ready_i;
  assign byte_mv = rx_take || tx_give;

  assign ring_wr    = pk_push || (host_push_i && !rd_dir);
  assign ring_wdata = rd_dir ? pk_word : host_wdata_i;
  assign ring_rd    = up_pop || (host_pop_i && rd_dir);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en     <= 1'b0;
      rd_dir <= 1'b0;
      armed  <= 1'b0;
      cnt    <= '0;
    end else if (start_i) begin
      en     <= 1'b1;
      rd_dir <= dir_rd_i;
      armed  <= 1'b1;
      cnt    <= len_i;
    end else begin
      if (en && drained) en <= 1'b0;
      if (byte_mv) cnt <= cnt - LEN_W'(1);
    end
  end

  bwf_word_ring #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_ring (
    .clk(clk), .rst_n(rst_n),
    .wr_req(ring_wr), .wr_data(ring_wdata),
    .rd_req(ring_rd), .head(head), .fill(fill)
  );

  bwf_packer #(.WIDTH(WIDTH)) u_pack (
    .clk(clk), .rst_n(rst_n), .restart(start_i),
    .take(rx_take), .last(cnt == LEN_W'(1)), .byte_in(card_rx_data_i),
    .push(pk_push), .push_word(pk_word)
  );

  bwf_unpacker #(.WIDTH(WIDTH)) u_unpack (
    .clk(clk), .rst_n(rst_n), .restart(start_i),
    .give(tx_give), .head(head),
    .have_bytes(up_have), .need_pop(up_pop), .byte_out(card_tx_data_o)
  );

  bwf_status #(.DEPTH(DEPTH)) u_stat (
    .live(en && !drained), .rd_dir(rd_dir), .fill(fill),
    .tx_flags(tx_flags_o), .rx_flags(rx_flags_o)
  );

  assign host_rdata_o = fifo_empty ? '0 : head;
  assign xfer_en_o    = en;
  assign remaining_o  = cnt;
  assign data_end_o   = armed && cnt_zero;
  assign blk_end_o    = armed && cnt_zero;
endmodule

// File: rtl/bwf_checker.sv
module bwf_checker #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 32,
  parameter int LEN_W = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [LEN_W-1:0] len,
  input logic             en,
  input logic [LEN_W-1:0] cnt,
  input logic [CW-1:0]    fill,
  input logic             byte_mv,
  input logic             rx_ready,
  input logic [4:0]       tx_flags,
  input logic [4:0]       rx_flags,
  input logic [WIDTH-1:0] rdata,
  input logic             data_end,
  input logic             blk_end
);
  AST_LOAD_ON_START: assert property (@(posedge clk) disable iff (!rst_n) start |=> (en && cnt == $past(len))); // R2
  AST_RX_HAS_ROOM: assert property (@(posedge clk) disable iff (!rst_n) rx_ready |-> (fill < CW'(DEPTH))); // R3
  AST_ONE_PER_BYTE: assert property (@(posedge clk) disable iff (!rst_n) (byte_mv && !start) |=> (cnt == $past(cnt) - LEN_W'(1))); // R6
  AST_HOLD_NO_BYTE: assert property (@(posedge clk) disable iff (!rst_n) (!byte_mv && !start) |=> $stable(cnt)); // R6
  AST_END_PAIR: assert property (@(posedge clk) disable iff (!rst_n) data_end == blk_end); // R7
  AST_EN_DROPS: assert property (@(posedge clk) disable iff (!rst_n) (en && cnt == '0 && fill == '0 && !start) |=> !en); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !en |-> (tx_flags == '0 && rx_flags == '0)); // R8
  AST_ONE_SIDE: assert property (@(posedge clk) disable iff (!rst_n) !((|tx_flags) && (|rx_flags))); // R10
  AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n) fill <= CW'(DEPTH)); // R11
  AST_EMPTY_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (fill == '0) |-> (rdata == '0)); // R11
endmodule

bind byte_word_fifo_engine bwf_checker #(.DEPTH(DEPTH), .WIDTH(WIDTH), .LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start_i), .len(len_i), .en(en), .cnt(cnt),
  .fill(fill), .byte_mv(byte_mv), .rx_ready(card_rx_ready_o),
  .tx_flags(tx_flags_o), .rx_flags(rx_flags_o), .rdata(host_rdata_o),
  .data_end(data_end_o), .blk_end(blk_end_o)
);

// File: tb/sim_byte_word_fifo_engine.sv
module sim_byte_word_fifo_engine;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        start_i = 0, dir_rd_i = 0, host_push_i = 0, host_pop_i = 0;
  logic [15:0] len_i = 0;
  logic [31:0] host_wdata_i = 0;
  logic        card_rx_valid_i = 0, card_tx_ready_i = 0;
  logic [7:0]  card_rx_data_i = 0;
  logic [31:0] host_rdata_o;
  logic        card_rx_ready_o, card_tx_valid_o, xfer_en_o, data_end_o, blk_end_o;
  logic [7:0]  card_tx_data_o;
  logic [15:0] remaining_o;
  logic [4:0]  tx_flags_o, rx_flags_o;

  byte_word_fifo_engine u0 (.*);

  int tests = 0, fails = 0, ncyc = 0;

  // Behavioural reference state
  logic [31:0] q[$];
  int m_cnt = 0, m_lane = 0, m_left = 0;
  bit m_en = 0, m_rd = 0, m_armed = 0;
  logic [31:0] m_acc = 0, m_hold = 0;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, exp, $time);
    end
  endtask

  function automatic bit e_ready();
    return m_en && m_rd && m_cnt != 0 && q.size() < 16 && !start_i;
  endfunction
  function automatic bit e_tvalid();
    return m_en && !m_rd && m_cnt != 0 && (m_left != 0 || q.size() != 0) && !start_i;
  endfunction
  function automatic logic [7:0] e_tdata();
    if (m_left != 0) return m_hold[7:0];
    return q[0][7:0];
  endfunction
  function automatic logic [4:0] e_set(bit for_rx);
    logic [4:0] f;
    int n;
    n = q.size();
    f = 5'd0;
    if (!m_en || (m_cnt == 0 && n == 0) || (m_rd != for_rx)) return f;
    f[0] = 1'b1;
    if (n == 0) f[1] = 1'b1; else f[2] = 1'b1;
    if (n == 16) f[3] = 1'b1;
    if (for_rx) f[4] = (n >= 8); else f[4] = (n <= 8);
    return f;
  endfunction

  task automatic compare_all();
    chk("R3", "rx_ready", {31'd0, card_rx_ready_o}, {31'd0, e_ready()});
    chk("R5", "tx_valid", {31'd0, card_tx_valid_o}, {31'd0, e_tvalid()});
    if (e_tvalid()) chk("R5", "tx_data", {24'd0, card_tx_data_o}, {24'd0, e_tdata()});
    chk("R6", "remaining", {16'd0, remaining_o}, 32'(m_cnt));
    chk("R8", "xfer_en", {31'd0, xfer_en_o}, {31'd0, m_en});
    chk("R9", "tx_flags", {27'd0, tx_flags_o}, {27'd0, e_set(1'b0)});
    chk("R10", "rx_flags", {27'd0, rx_flags_o}, {27'd0, e_set(1'b1)});
    chk("R7", "data_end", {31'd0, data_end_o}, {31'd0, m_armed && m_cnt == 0});
    chk("R7", "blk_end", {31'd0, blk_end_o}, {31'd0, m_armed && m_cnt == 0});
    chk("R11", "host_rdata", host_rdata_o, (q.size() != 0) ? q[0] : 32'd0);
  endtask

  task automatic model_edge();
    bit rdy, tv, hpush, hpop;
    int fill0, cnt0;
    logic [31:0] w;
    rdy = e_ready(); tv = e_tvalid();
    fill0 = q.size(); cnt0 = m_cnt;
    hpush = host_push_i && !m_rd && fill0 < 16;
    hpop  = host_pop_i && m_rd && fill0 > 0;
    if (hpop) void'(q.pop_front());
    if (rdy && card_rx_valid_i) begin
      m_acc = m_acc | ({24'd0, card_rx_data_i} << (8 * m_lane));
      if (m_lane == 3 || m_cnt == 1) begin q.push_back(m_acc); m_acc = 0; m_lane = 0; end
      else m_lane++;
      m_cnt--;
    end
    if (tv && card_tx_ready_i) begin
      if (m_left == 0) begin w = q.pop_front(); m_hold = w >> 8; m_left = 3; end
      else begin m_hold = m_hold >> 8; m_left--; end
      m_cnt--;
    end
    if (hpush) q.push_back(host_wdata_i);
    if (start_i) begin
      m_cnt = int'(len_i); m_en = 1; m_rd = dir_rd_i; m_armed = 1;
      m_lane = 0; m_acc = 0; m_left = 0;
    end else if (m_en && cnt0 == 0 && fill0 == 0) m_en = 0;
  endtask

  task automatic cyc();
    #1;
    compare_all();
    @(posedge clk);
    if (!rst_n) begin
      q.delete(); m_cnt = 0; m_lane = 0; m_left = 0; m_en = 0; m_rd = 0; m_armed = 0; m_acc = 0;
    end else model_edge();
    @(negedge clk);
  endtask

  task automatic go(bit rd, int len);
    start_i = 1; dir_rd_i = rd; len_i = 16'(len);
    cyc();
    start_i = 0;
  endtask

  always @(posedge clk) begin
    ncyc++;
    if (ncyc > 50000) begin
      fails++; tests++;
      $display("FAIL R8 watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] seq;
    @(posedge clk); @(negedge clk);
    // R1: reset state
    for (int i = 0; i < 2; i++) begin
      #1;
      chk("R1", "xfer_en", {31'd0, xfer_en_o}, 0);
      chk("R1", "remaining", {16'd0, remaining_o}, 0);
      chk("R1", "flags", {22'd0, tx_flags_o, rx_flags_o}, 0);
      chk("R1", "ends", {30'd0, data_end_o, blk_end_o}, 0);
      chk("R1", "handshakes", {30'd0, card_rx_ready_o, card_tx_valid_o}, 0);
      chk("R1", "rdata", host_rdata_o, 0);
      cyc();
    end
    rst_n = 1;
    cyc();
    host_pop_i = 1; cyc(); host_pop_i = 0;  // R11 pop on empty ignored
    cyc();

    // Short read: 5 bytes, partial last word
    go(1, 5);
    chk("R2", "remaining after start", {16'd0, remaining_o}, 5);
    for (int i = 0; i < 5; i++) begin
      card_rx_valid_i = 1; card_rx_data_i = 8'(8'h11 * (i + 1));
      host_push_i = (i == 2); host_wdata_i = 32'hDEAD_BEEF;  // R11 ignored in read dir
      cyc();
    end
    card_rx_valid_i = 0; host_push_i = 0;
    #1 chk("R3", "packed word", host_rdata_o, 32'h4433_2211);
    host_pop_i = 1; cyc();
    #1 chk("R4", "partial word", host_rdata_o, 32'h0000_0055);
    cyc(); host_pop_i = 0;
    cyc(); cyc();

    // Long read with FIFO full stall, then draining
    go(1, 70);
    seq = 8'd3;
    for (int i = 0; i < 260; i++) begin
      card_rx_valid_i = (i % 3 != 0);
      card_rx_data_i = seq;
      host_pop_i = (i > 40) && (i % 2 == 0);
      if (card_rx_valid_i && e_ready()) seq = seq + 8'd37;
      cyc();
    end
    card_rx_valid_i = 0; host_pop_i = 0;
    cyc();

    // Short write: explicit byte order
    go(0, 6);
    host_push_i = 1; host_wdata_i = 32'hA1B2_C3D4; cyc();
    host_wdata_i = 32'h0000_EEFF; cyc();
    host_push_i = 0;
    card_tx_ready_i = 1;
    begin
      logic [7:0] exp_b[6] = '{8'hD4, 8'hC3, 8'hB2, 8'hA1, 8'hFF, 8'hEE};
      for (int i = 0; i < 6; i++) begin
        #1 chk("R5", "unpack order", {24'd0, card_tx_data_o}, {24'd0, exp_b[i]});
        cyc();
      end
    end
    card_tx_ready_i = 0;
    cyc(); cyc();

    // Long write: overfill the FIFO, then drain with a stalling card
    go(0, 40);
    for (int i = 0; i < 17; i++) begin
      host_push_i = 1; host_wdata_i = 32'h1000_0000 + 32'(i) * 32'h0101_0101;
      cyc();
    end
    host_push_i = 0;
    for (int i = 0; i < 100; i++) begin
      card_tx_ready_i = (i % 2 == 1);
      host_pop_i = (i == 5);  // R11 ignored in write dir
      cyc();
    end
    card_tx_ready_i = 0; host_pop_i = 0;

    // Zero-length read with leftover words, then empty zero-length
    go(1, 0);
    for (int i = 0; i < 9; i++) begin host_pop_i = 1; cyc(); end
    host_pop_i = 0;
    go(1, 0);
    cyc(); cyc();

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule